// File: doc/BRIEF.md
# Programmable 3x3 Color Matrix

This block converts one pixel per clock from one color space to another. Each pixel arrives as three unsigned 12-bit components. Each of the three output components is a signed weighted sum of all three input components, scaled by a shared power of two, rounded to nearest and offset. The result is then clamped to the unsigned 12-bit range. With the right coefficients the matrix passes pixels through unchanged. Other coefficient sets give RGB-to-YCbCr, YCbCr-to-RGB or any other linear mapping.

Twelve signed 13-bit values configure the matrix: three weights and one offset per output row. A 2-bit scale field selects the power of two. The configuration arrives on plain input ports, driven by whatever register file sits beside the block. The block copies that configuration into an internal working set only while the data-enable input is low. A line of active video is therefore always converted with a single coefficient set. Valid and data-enable travel through the same three-stage pipeline as the pixel data.

Top module: `colorMatrix`

## Requirements
- R1: `outValid` and `outDe` equal `inValid` and `inDe` from exactly three rising clock edges earlier, and every valid pixel's result appears on `outPix` together with its `outValid`.
- R2: Component 0 (R/Cr) occupies bits [35:24], component 1 (G/Y) bits [23:12] and component 2 (B/Cb) bits [11:0], on both `inPix` and `outPix`; output component k is computed by row k. Configuration entry e = 4*k + j sits at `cfgCoef[13*e +: 13]`: j = 0, 1, 2 is row k's weight for input component j, and j = 3 is row k's offset.
- R3: With scale s, output k = floor((sum over j of w[k][j]*in[j]*2^s + 2048) / 4096) + off[k]*2^s. Weights and offsets are two's complement and inputs are unsigned. The result is then clamped per R5.
- R4: `cfgMode` values 0, 1 and 2 select scale s = 0, 1 and 2; value 3 behaves exactly like value 2.
- R5: Each output component saturates: a negative result gives 0 and a result above 4095 gives 4095.
- R6: Rounding is half-up in the signed domain: a product sum that lands exactly on half an output step rounds up, and one just below it rounds down (negative sums included).
- R7: A pixel presented with `inDe` low uses the configuration on the ports in that cycle. A pixel presented with `inDe` high uses the configuration captured in the most recent cycle in which `inDe` was low. Changes to `cfgCoef` or `cfgMode` while `inDe` is high have no effect on any pixel until `inDe` goes low.
- R8: After reset, `outValid`, `outDe` and `outPix` are 0, and the working configuration is all zero (every coefficient, every offset and scale 0). A pixel presented with `inDe` high before any cycle with `inDe` low therefore converts to 0.
- R9: The block accepts a new pixel on every clock with no stall, and it produces exactly one result for each valid input.
- R10: `outPix` holds its last value during cycles in which `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pixel qualifier |
| inDe | input | 1 | Input data enable (active video); low cycles load the configuration |
| inPix | input | 36 | Input components, component 0 in the top bits |
| cfgCoef | input | 156 | Twelve 13-bit signed weights and offsets, entry 4*row+term |
| cfgMode | input | 2 | Shared scale select, 3 aliases 2 |
| outValid | output | 1 | Output pixel qualifier |
| outDe | output | 1 | Delayed data enable |
| outPix | output | 36 | Converted components, same layout as inPix |

## Verification
The latency properties assume that `inValid` and `inDe` hold known 0/1 values at every clock edge once reset is released. These properties are armed only after three edges out of reset, so the input values held during reset do not matter. The clamp and hold properties assume no input behaviour at all. The stimulus drives every input on the falling edge, keeps each weight and offset inside the 13-bit signed range, and stages configuration updates so that they reach the ports together with the pixel they are meant for.

// File: rtl/cscPkg.sv
package cscPkg;
  // matrix geometry: three rows, each with three weights and one offset
  localparam int NUM_CH  = 3;
  localparam int TERMS   = NUM_CH;
  localparam int ENTRIES = TERMS + 1;
  // fixed pipeline depth from input port to output register
  localparam int STAGES  = 3;

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic              useLive;  // take the configuration from the ports this cycle
    logic [STAGES-1:0] stgEn;    // per-stage register enable (pixel present)
  } cscStrobe_t;
endpackage

// File: rtl/cscCtrl.sv
module cscCtrl
  import cscPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inDe,
  output cscStrobe_t strobe,
  output logic       outValid,
  output logic       outDe
);
  localparam int WARM_W = $clog2(STAGES + 1);

  logic [STAGES-1:0] vPipe;
  logic [STAGES-1:0] dPipe;
  logic [WARM_W-1:0] warmCnt;  // edges since reset, saturating; arms the latency checks

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vPipe   <= '0;
      dPipe   <= '0;
      warmCnt <= '0;
    end else begin
      vPipe <= {vPipe[STAGES-2:0], inValid};
      dPipe <= {dPipe[STAGES-2:0], inDe};
      if (warmCnt != WARM_W'(STAGES)) warmCnt <= warmCnt + WARM_W'(1);
    end
  end

  always_comb begin
    strobe.useLive = !inDe;
    strobe.stgEn   = {vPipe[STAGES-2:0], inValid};
  end

  assign outValid = vPipe[STAGES-1];
  assign outDe    = dPipe[STAGES-1];

  // R1: valid and data enable leave exactly STAGES edges after they enter
  p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == WARM_W'(STAGES)) |-> (outValid == $past(inValid, STAGES)));
  p_de_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == WARM_W'(STAGES)) |-> (outDe == $past(inDe, STAGES)));
endmodule

// File: rtl/cscLane.sv
module cscLane
  import cscPkg::*;
#(
  parameter int DATA_W = 12,
  parameter int COEF_W = 13,
  parameter int FRAC_W = 12,
  parameter int MODE_W = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  cscStrobe_t                    strobe,
  input  logic [TERMS-1:0][DATA_W-1:0]  comps,
  input  logic [TERMS-1:0][COEF_W-1:0]  weights,
  input  logic [COEF_W-1:0]             offset,
  input  logic [MODE_W-1:0]             shift,
  output logic [DATA_W-1:0]             outComp
);
  localparam int MAX_SHIFT = (1 << MODE_W) - 2;
  localparam int PROD_W    = DATA_W + COEF_W + 1;
  localparam int ACC_W     = PROD_W + $clog2(TERMS) + MAX_SHIFT + 1;
  localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(1 << (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] OUT_MAX = ACC_W'((1 << DATA_W) - 1);

  // stage 1: products and scaled offset
  logic signed [PROD_W-1:0] prodNext [TERMS];
  logic signed [PROD_W-1:0] prodS1   [TERMS];
  logic signed [ACC_W-1:0]  offNext;
  logic signed [ACC_W-1:0]  offS1;
  logic [MODE_W-1:0]        shiftS1;

  always_comb begin
    for (int j = 0; j < TERMS; j++) begin
      prodNext[j] = PROD_W'(signed'({1'b0, comps[j]})) * PROD_W'(signed'(weights[j]));
    end
    offNext = ACC_W'(signed'(offset)) <<< shift;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < TERMS; j++) prodS1[j] <= '0;
      offS1   <= '0;
      shiftS1 <= '0;
    end else if (strobe.stgEn[0]) begin
      for (int j = 0; j < TERMS; j++) prodS1[j] <= prodNext[j];
      offS1   <= offNext;
      shiftS1 <= shift;
    end
  end

  // stage 2: sum, scale, round, offset
  logic signed [ACC_W-1:0] sumS1;
  logic signed [ACC_W-1:0] scaled;
  logic signed [ACC_W-1:0] rndSum;
  logic signed [ACC_W-1:0] rounded;
  logic signed [ACC_W-1:0] resNext;
  logic signed [ACC_W-1:0] resS2;

  always_comb begin
    sumS1 = '0;
    for (int j = 0; j < TERMS; j++) sumS1 = sumS1 + ACC_W'(prodS1[j]);
    scaled  = sumS1 <<< shiftS1;
    rndSum  = scaled + HALF;
    rounded = rndSum >>> FRAC_W;
    resNext = rounded + offS1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resS2 <= '0;
    else if (strobe.stgEn[1]) resS2 <= resNext;
  end

  // stage 3: saturate into the unsigned output range
  always_ff @(posedge clk) begin
    if (!rstN) outComp <= '0;
    else if (strobe.stgEn[2]) begin
      if (resS2 < 0)            outComp <= '0;
      else if (resS2 > OUT_MAX) outComp <= '1;
      else                      outComp <= resS2[DATA_W-1:0];
    end
  end

  // R5: saturation at both ends
  p_clamp_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stgEn[2] && (resS2 < 0)) |=> (outComp == '0));
  p_clamp_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stgEn[2] && (resS2 > OUT_MAX)) |=> (outComp == {DATA_W{1'b1}}));
  // R10: the output register holds while no pixel leaves
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.stgEn[2] |=> $stable(outComp));
endmodule

// File: rtl/cscDatapath.sv
module cscDatapath
  import cscPkg::*;
#(
  parameter int DATA_W = 12,
  parameter int COEF_W = 13,
  parameter int FRAC_W = 12,
  parameter int MODE_W = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  cscStrobe_t                        strobe,
  input  logic [NUM_CH*DATA_W-1:0]          inPix,
  input  logic [NUM_CH*ENTRIES*COEF_W-1:0]  cfgCoef,
  input  logic [MODE_W-1:0]                 cfgMode,
  output logic [NUM_CH*DATA_W-1:0]          outPix
);
  localparam int CFG_W = NUM_CH * ENTRIES * COEF_W;
  localparam logic [MODE_W-1:0] MODE_TOP = '1;

  // working configuration, refreshed only while data enable is low
  logic [CFG_W-1:0]  activeCoef;
  logic [CFG_W-1:0]  effCoef;
  logic [MODE_W-1:0] activeMode;
  logic [MODE_W-1:0] effMode;
  logic [MODE_W-1:0] effShift;

  always_comb begin
    effCoef  = strobe.useLive ? cfgCoef : activeCoef;
    effMode  = strobe.useLive ? cfgMode : activeMode;
    // the top code is reserved and aliases the one below it
    effShift = (effMode == MODE_TOP) ? (MODE_TOP - MODE_W'(1)) : effMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeCoef <= '0;
      activeMode <= '0;
    end else begin
      activeCoef <= effCoef;
      activeMode <= effMode;
    end
  end

  logic [TERMS-1:0][DATA_W-1:0] comps;
  always_comb begin
    for (int j = 0; j < TERMS; j++) comps[j] = inPix[(TERMS-1-j)*DATA_W +: DATA_W];
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
    logic [TERMS-1:0][COEF_W-1:0] laneW;
    logic [COEF_W-1:0]            laneOff;
    logic [DATA_W-1:0]            laneOut;

    for (genvar j = 0; j < TERMS; j++) begin : g_term
      assign laneW[j] = effCoef[(k*ENTRIES+j)*COEF_W +: COEF_W];
    end
    assign laneOff = effCoef[(k*ENTRIES+TERMS)*COEF_W +: COEF_W];

    cscLane #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .MODE_W(MODE_W)
    ) u_lane (
      .clk     (clk),
      .rstN    (rstN),
      .strobe  (strobe),
      .comps   (comps),
      .weights (laneW),
      .offset  (laneOff),
      .shift   (effShift),
      .outComp (laneOut)
    );

    assign outPix[(NUM_CH-1-k)*DATA_W +: DATA_W] = laneOut;
  end

  // R7: the working set is frozen while active video is flowing
  p_freeze_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.useLive |=> ($stable(activeCoef) && $stable(activeMode)));
endmodule

// File: rtl/colorMatrix.sv
module colorMatrix
  import cscPkg::*;
#(
  parameter int DATA_W = 12,
  parameter int COEF_W = 13,
  parameter int FRAC_W = 12,
  parameter int MODE_W = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              inValid,
  input  logic                              inDe,
  input  logic [NUM_CH*DATA_W-1:0]          inPix,
  input  logic [NUM_CH*ENTRIES*COEF_W-1:0]  cfgCoef,
  input  logic [MODE_W-1:0]                 cfgMode,
  output logic                              outValid,
  output logic                              outDe,
  output logic [NUM_CH*DATA_W-1:0]          outPix
);
  cscStrobe_t strobe;

  cscCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inDe     (inDe),
    .strobe   (strobe),
    .outValid (outValid),
    .outDe    (outDe)
  );

  cscDatapath #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .MODE_W(MODE_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inPix   (inPix),
    .cfgCoef (cfgCoef),
    .cfgMode (cfgMode),
    .outPix  (outPix)
  );
endmodule

// File: tb/tb_colorMatrix.sv
module tb_colorMatrix;
  import cscPkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 12;
  localparam int COEF_W = 13;
  localparam int MODE_W = 2;
  localparam int CFG_W  = NUM_CH * ENTRIES * COEF_W;
  localparam int PIX_W  = NUM_CH * DATA_W;

  logic              clk = 1'b0;
  logic              rstN;
  logic              inValid;
  logic              inDe;
  logic [PIX_W-1:0]  inPix;
  logic [CFG_W-1:0]  cfgCoef;
  logic [MODE_W-1:0] cfgMode;
  logic              outValid;
  logic              outDe;
  logic [PIX_W-1:0]  outPix;

  colorMatrix dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDe(inDe), .inPix(inPix),
    .cfgCoef(cfgCoef), .cfgMode(cfgMode),
    .outValid(outValid), .outDe(outDe), .outPix(outPix)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic             de;
    logic [PIX_W-1:0] pix;
    string            tag;
  } exp_t;

  exp_t sbQ[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int liveW [NUM_CH][ENTRIES];
  int frzW  [NUM_CH][ENTRIES];
  int liveMode;
  int frzMode;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // expected output of row k from the requirement formula
  function automatic int rowModel(input int k, input bit useFrz, input int c0, input int c1, input int c2);
    longint sum, scaled, r, o;
    int m, s;
    int w [ENTRIES];
    for (int j = 0; j < ENTRIES; j++) w[j] = useFrz ? frzW[k][j] : liveW[k][j];
    m = useFrz ? frzMode : liveMode;
    s = (m == 3) ? 2 : m;
    sum    = longint'(w[0]) * c0 + longint'(w[1]) * c1 + longint'(w[2]) * c2;
    scaled = sum * (longint'(1) << s);
    r      = (scaled + 2048) >>> 12;
    o      = r + longint'(w[3]) * (longint'(1) << s);
    if (o < 0) o = 0;
    if (o > 4095) o = 4095;
    return int'(o);
  endfunction

  task automatic setRow(input int k, input int w0, input int w1, input int w2, input int off);
    liveW[k][0] = w0; liveW[k][1] = w1; liveW[k][2] = w2; liveW[k][3] = off;
  endtask

  task automatic setDiag(input int w, input int mode);
    for (int k = 0; k < NUM_CH; k++) setRow(k, (k == 0) ? w : 0, (k == 1) ? w : 0, (k == 2) ? w : 0, 0);
    liveMode = mode;
  endtask

  task automatic drive(input bit v, input bit de, input int r, input int g, input int b, input string tag);
    exp_t e;
    int o0, o1, o2;
    @(negedge clk);
    inValid = v;
    inDe    = de;
    inPix   = {DATA_W'(r), DATA_W'(g), DATA_W'(b)};
    for (int k = 0; k < NUM_CH; k++)
      for (int j = 0; j < ENTRIES; j++)
        cfgCoef[(k*ENTRIES+j)*COEF_W +: COEF_W] = COEF_W'(liveW[k][j]);
    cfgMode = MODE_W'(liveMode);
    if (v) begin
      o0 = rowModel(0, de, r, g, b);
      o1 = rowModel(1, de, r, g, b);
      o2 = rowModel(2, de, r, g, b);
      e.de  = de;
      e.pix = {DATA_W'(o0), DATA_W'(o1), DATA_W'(o2)};
      e.tag = tag;
      sbQ.push_back(e);
    end
    if (!de) begin
      frzW    = liveW;
      frzMode = liveMode;
    end
  endtask

  // bench-side delay line for the R1 latency check
  logic [2:0] dlyV, dlyD;
  always @(posedge clk) begin
    if (!rstN) begin
      dlyV <= '0;
      dlyD <= '0;
    end else begin
      dlyV <= {dlyV[1:0], inValid};
      dlyD <= {dlyD[1:0], inDe};
    end
  end

  logic [PIX_W-1:0] lastPix;
  bit haveLast = 0;

  // monitor: pops the scoreboard as results leave
  always @(negedge clk) begin
    exp_t e;
    if (rstN === 1'b1 && !finished) begin
      check(outValid == dlyV[2], "R1", "outValid latency", longint'(outValid), longint'(dlyV[2]));
      check(outDe == dlyD[2], "R1", "outDe latency", longint'(outDe), longint'(dlyD[2]));
      if (outValid) begin
        if (sbQ.size() == 0) begin
          check(1'b0, "R9", "unexpected output", longint'(outPix), 0);
        end else begin
          e = sbQ.pop_front();
          check(outPix == e.pix, e.tag, "pixel", longint'(outPix), longint'(e.pix));
          check(outDe == e.de, e.tag, "pixel de", longint'(outDe), longint'(e.de));
        end
        lastPix  = outPix;
        haveLast = 1;
      end else if (haveLast) begin
        check(outPix == lastPix, "R10", "hold", longint'(outPix), longint'(lastPix));
      end
    end
  end

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NUM_CH; k++)
      for (int j = 0; j < ENTRIES; j++) begin
        liveW[k][j] = 0;
        frzW[k][j]  = 0;
      end
    liveMode = 0;
    frzMode  = 0;
    rstN    = 1'b0;
    inValid = 1'b0;
    inDe    = 1'b1;
    inPix   = '0;
    cfgCoef = '0;
    cfgMode = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8: reset state
    check(outValid == 1'b0, "R8", "reset outValid", longint'(outValid), 0);
    check(outDe == 1'b0, "R8", "reset outDe", longint'(outDe), 0);
    check(outPix == '0, "R8", "reset outPix", longint'(outPix), 0);

    // R8: live config is nonzero but no DE-low cycle has loaded it yet
    setDiag(1024, 2);
    drive(1, 1, 1000, 2000, 3000, "R8");
    drive(1, 1, 4095, 1, 77, "R8");

    // R2/R3: pass-through in scale 2, distinct components
    drive(0, 0, 0, 0, 0, "R7");
    drive(1, 1, 100, 2000, 4000, "R2");
    drive(1, 1, 4095, 0, 1, "R2");
    drive(1, 1, 1234, 2345, 3456, "R3");

    // R4: code 3 behaves like scale 2
    liveMode = 3;
    drive(0, 0, 0, 0, 0, "R4");
    drive(1, 1, 321, 654, 987, "R4");
    drive(1, 1, 4000, 17, 2048, "R4");

    // R3/R4: full matrix with offsets in scales 0 and 1
    setRow(0, 1076, 2109, 410, 16);
    setRow(1, -620, -1213, 1833, 128);
    setRow(2, 1833, -1535, -298, 128);
    liveMode = 0;
    drive(0, 0, 0, 0, 0, "R3");
    drive(1, 1, 4095, 4095, 4095, "R3");
    drive(1, 1, 800, 1600, 2400, "R3");
    liveMode = 1;
    drive(1, 0, 3000, 200, 1000, "R4");
    drive(1, 1, 2500, 2500, 100, "R4");

    // R5: saturation both ways
    setRow(0, 4095, 4095, 4095, 0);
    setRow(1, -4096, -4096, -4096, 0);
    setRow(2, 0, 0, 0, 4095);
    liveMode = 2;
    drive(0, 0, 0, 0, 0, "R5");
    drive(1, 1, 4095, 4095, 4095, "R5");
    drive(1, 1, 2000, 10, 10, "R5");

    // R6: half-step rounding, positive and negative
    setRow(0, 1, 0, 0, 10);
    setRow(1, -1, 0, 0, 10);
    setRow(2, 0, 0, 0, -5);
    liveMode = 0;
    drive(0, 0, 0, 0, 0, "R6");
    drive(1, 1, 2047, 0, 0, "R6");
    drive(1, 1, 2048, 0, 0, "R6");
    drive(1, 1, 2049, 0, 0, "R6");

    // R7: config changes mid-line are ignored until DE falls
    setDiag(1024, 2);
    drive(1, 0, 500, 600, 700, "R7");
    drive(1, 1, 500, 600, 700, "R7");
    setRow(0, -2048, 1024, 512, 300);
    setRow(1, 2048, 2048, 0, -100);
    setRow(2, 0, -1024, 4095, 50);
    liveMode = 1;
    drive(1, 1, 500, 600, 700, "R7");
    drive(1, 1, 1500, 2600, 3700, "R7");
    drive(0, 1, 0, 0, 0, "R7");
    drive(1, 0, 1500, 2600, 3700, "R7");
    drive(1, 1, 1500, 2600, 3700, "R7");

    // R9: back-to-back lines with random pixels and configs
    for (int line = 0; line < 10; line++) begin
      for (int k = 0; k < NUM_CH; k++)
        setRow(k, $urandom_range(8191) - 4096, $urandom_range(8191) - 4096,
               $urandom_range(8191) - 4096, $urandom_range(8191) - 4096);
      liveMode = $urandom_range(3);
      for (int p = 0; p < 20; p++) begin
        if (p == 10) begin
          setRow(0, $urandom_range(8191) - 4096, 0, 0, 0);
          liveMode = $urandom_range(3);
        end
        drive((p % 7) != 6, 1, $urandom_range(4095), $urandom_range(4095),
              $urandom_range(4095), "R9");
      end
      for (int p = 0; p < 3; p++)
        drive(p != 1, 0, $urandom_range(4095), $urandom_range(4095),
              $urandom_range(4095), "R9");
    end

    // drain; idle cycles also exercise R10
    for (int p = 0; p < 8; p++) drive(0, 0, 0, 0, 0, "R10");
    check(sbQ.size() == 0, "R9", "results outstanding", longint'(sbQ.size()), 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule